// File: doc/BRIEF.md
# Interrupt Group Summary Aggregator

This block merges the requests of three interrupt groups (receive, transmit and miscellaneous) into one summary register and one level interrupt line toward the host. Each group presents a single request level, which is the OR of that group's own pending causes. The block latches each group's request into its own summary bit. A software mask register decides which summary bits may drive the line.

A handler reads the summary over a small register port. The read returns the summary and clears it in the same access, so no acknowledge write is needed. A summary of zero means nothing is pending. To block the whole line while it services the groups, the handler writes all ones to the mask. To unmask, it writes a word that is 0 only at the three group positions.

The register port is a plain strobe interface and has no back-pressure. Every access is taken in the cycle it is presented. Read data comes back one cycle later with a single-cycle `rd_valid_o` pulse, which the requester must accept in that cycle.

Top module: `pca_irq_agg`

## Requirements
- R1: After reset the summary is 0, the mask register is all ones, `irq_o` is low and `rd_valid_o` is low.
- R2: Summary bit 0 belongs to receive, bit 1 to transmit and bit 2 to miscellaneous, and bits above 2 read 0. A request held high for one cycle sets its bit from the next cycle on, and the bit stays set after the request drops.
- R3: A read at address 0 returns the summary as it stood before the read. `rd_valid_o` pulses in the cycle after the strobe, and the read clears the summary.
- R4: A request that is high in the same cycle as a summary read is not lost: its bit is set in the summary right after the read.
- R5: A request that stays high across a read sets its bit again, so the next read returns it once more.
- R6: `irq_o` is high exactly when some summary bit is set while its mask bit is 0. A mask with all ones holds `irq_o` low.
- R7: A write at address 1 loads the full-width mask from the next cycle on, and a read at address 1 returns it. Only mask bits 2..0 gate the line.
- R8: A write at address 0 leaves the summary unchanged.
- R9: With a summary of zero, `irq_o` stays low under any mask, including all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_req_i | input | 3 | Group request levels: bit 0 receive, bit 1 transmit, bit 2 miscellaneous |
| bus_sel_i | input | 1 | Access strobe, one access per cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 = summary, 1 = mask, others read 0 |
| bus_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid when rd_valid_o is high |
| rd_valid_o | output | 1 | One-cycle pulse in the cycle after a read strobe |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The bench targets a request that coincides with a clearing read. A design that applied the clear after the set would drop that request, and the handler would never see it. It holds a request high across two reads, which catches a summary that latches only on the rising edge and so goes quiet. It checks that only the low three mask bits gate the line: a wrong slice would raise `irq_o` for a masked group or keep it low for an unmasked one. It also writes the summary address and expects no change, which exposes a decoder that lets writes clear or load the summary.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int unsigned GRP_N   = 3;
  localparam int unsigned GRP_RX  = 0;
  localparam int unsigned GRP_TX  = 1;
  localparam int unsigned GRP_MSC = 2;

  localparam logic [1:0] ADR_SUMMARY = 2'd0;
  localparam logic [1:0] ADR_MASK    = 2'd1;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/pca_summary.sv
module pca_summary #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         clr_i,
  output logic [N-1:0] sum_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= (bit_q & ~clr_i) | req_i[g];
    end
    assign sum_o[g] = bit_q;
  end
endmodule

// File: rtl/pca_mask.sv
module pca_mask #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= '1;
    else if (we_i) mask_q <= wdata_i;
  end
  assign mask_o = mask_q;
endmodule

// File: rtl/pca_rdport.sv
module pca_rdport #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_i,
  input  logic         pick_sum_i,
  input  logic         pick_mask_i,
  input  logic [N-1:0] sum_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] rdata_o,
  output logic         rvalid_o
);
  localparam int unsigned PAD = W - N;
  logic [W-1:0] mux_d;
  logic [W-1:0] rdata_q;
  logic         rvalid_q;

  always_comb begin
    mux_d = '0;
    if (pick_sum_i)  mux_d = {{PAD{1'b0}}, sum_i};
    if (pick_mask_i) mux_d = mask_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= mux_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/pca_irq_agg.sv
module pca_irq_agg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        grp_req_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              irq_o
);
  import pca_pkg::*;
  localparam int unsigned N = GRP_N;

  acc_kind_e     kind;
  logic          hit_sum, hit_mask;
  logic [N-1:0]  sum_q;
  logic [DATA_W-1:0] mask_q;
  logic [N-1:0]  live;

  always_comb begin
    kind = ACC_IDLE;
    if (bus_sel_i) kind = bus_wr_i ? ACC_WRITE : ACC_READ;
    hit_sum  = (bus_addr_i == ADDR_W'(ADR_SUMMARY));
    hit_mask = (bus_addr_i == ADDR_W'(ADR_MASK));
  end

  pca_summary #(.N(N)) u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (grp_req_i),
    .clr_i (kind == ACC_READ && hit_sum),
    .sum_o (sum_q)
  );

  pca_mask #(.W(DATA_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (kind == ACC_WRITE && hit_mask),
    .wdata_i (bus_wdata_i),
    .mask_o  (mask_q)
  );

  pca_rdport #(.W(DATA_W), .N(N)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_i        (kind == ACC_READ),
    .pick_sum_i  (hit_sum),
    .pick_mask_i (hit_mask),
    .sum_i       (sum_q),
    .mask_i      (mask_q),
    .rdata_o     (rd_data_o),
    .rvalid_o    (rd_valid_o)
  );

  for (genvar g = 0; g < N; g++) begin : g_gate
    assign live[g] = sum_q[g] & ~mask_q[g];
  end
  assign irq_o = |live;
endmodule

// File: rtl/pca_irq_agg_chk.sv
module pca_irq_agg_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        grp_req_i,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic              irq_o,
  input logic [2:0]        sum_q,
  input logic [DATA_W-1:0] mask_q
);
  logic rd_sum, wr_sum, wr_mask, rd_any;
  assign rd_any  = bus_sel_i && !bus_wr_i;
  assign rd_sum  = rd_any && bus_addr_i == '0;
  assign wr_sum  = bus_sel_i && bus_wr_i && bus_addr_i == '0;
  assign wr_mask = bus_sel_i && bus_wr_i && bus_addr_i == ADDR_W'(1);

  assert_req_sets_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_req_i) |=> ((sum_q & $past(grp_req_i)) == $past(grp_req_i)));

  assert_read_returns_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sum |=> (rd_valid_o && rd_data_o == {{(DATA_W-3){1'b0}}, $past(sum_q)}));

  assert_valid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_any));

  assert_irq_needs_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((sum_q & ~mask_q[2:0]) != 3'b000));

  assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(bus_wdata_i)));

  assert_sum_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sum && grp_req_i == 3'b000) |=> $stable(sum_q));

  assert_zero_sum_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q == 3'b000) |-> !irq_o);
endmodule

bind pca_irq_agg pca_irq_agg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .grp_req_i   (grp_req_i),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .rd_data_o   (rd_data_o),
  .rd_valid_o  (rd_valid_o),
  .irq_o       (irq_o),
  .sum_q       (sum_q),
  .mask_q      (mask_q)
);

// File: tb/pca_irq_agg_tb.sv
module pca_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  req;
  logic        sel, wr;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rvalid, irq;

  int n_run = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t  expq[$];
  string cur_tag = "R1";

  logic [2:0]  m_sum;
  logic [31:0] m_mask;

  always #4 clk = ~clk;

  pca_irq_agg u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_req_i   (req),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .rd_data_o   (rdata),
    .rd_valid_o  (rvalid),
    .irq_o       (irq)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model built from the requirements; feeds the scoreboard queue
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sum  <= 3'b000;
      m_mask <= 32'hFFFF_FFFF;
    end else begin
      if (sel && !wr) begin
        exp_t e;
        e.tag = cur_tag;
        e.val = (addr == 2'd0) ? {29'd0, m_sum} : (addr == 2'd1) ? m_mask : 32'd0;
        expq.push_back(e);
      end
      m_sum <= (((sel && !wr && addr == 2'd0)) ? 3'b000 : m_sum) | req;
      if (sel && wr && addr == 2'd1) m_mask <= wdata;
    end
  end

  // monitor: pop and compare each returned read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R3 unexpected rd_valid", rdata, 32'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(rdata === e.val, e.tag, rdata, e.val);
      end
    end
  end

  task automatic tick(input logic [2:0] r, input logic s, input logic w,
                      input logic [1:0] a, input logic [31:0] d);
    req = r; sel = s; wr = w; addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic idle(input logic [2:0] r);
    tick(r, 1'b0, 1'b0, 2'd0, 32'd0);
  endtask

  task automatic rd(input logic [1:0] a, input logic [2:0] r, input string tag);
    cur_tag = tag;
    tick(r, 1'b1, 1'b0, a, 32'd0);
  endtask

  task automatic wrm(input logic [1:0] a, input logic [31:0] d);
    tick(3'b000, 1'b1, 1'b1, a, d);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req = 0; sel = 0; wr = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, 32'd0);
    check(rvalid === 1'b0, "R1 rd_valid after reset", {31'd0, rvalid}, 32'd0);
    rd(2'd1, 3'b000, "R1 mask resets to ones");
    rd(2'd0, 3'b000, "R1 summary resets to zero");
    idle(3'b000);
    // R2 positions and stickiness; R6 mask all ones holds irq low
    idle(3'b001);
    idle(3'b000);
    check(irq === 1'b0, "R6 all-ones mask blocks", {31'd0, irq}, 32'd0);
    rd(2'd0, 3'b000, "R2 receive at bit 0");
    idle(3'b110);
    idle(3'b000);
    rd(2'd0, 3'b000, "R2 transmit and misc at bits 1,2");
    rd(2'd0, 3'b000, "R3 read cleared summary");
    idle(3'b000);
    // R6 unmask with only group bits at 0
    wrm(2'd1, 32'hFFFF_FFF8);
    check(irq === 1'b0, "R9 empty summary no irq", {31'd0, irq}, 32'd0);
    idle(3'b010);
    check(irq === 1'b1, "R6 unmasked transmit raises irq", {31'd0, irq}, 32'd1);
    rd(2'd0, 3'b000, "R3 read returns transmit");
    check(irq === 1'b0, "R6 irq drops after clearing read", {31'd0, irq}, 32'd0);
    // R7 partial mask: only transmit open
    wrm(2'd1, 32'hFFFF_FFFD);
    idle(3'b001);
    check(irq === 1'b0, "R7 masked receive stays low", {31'd0, irq}, 32'd0);
    idle(3'b010);
    check(irq === 1'b1, "R7 open transmit raises irq", {31'd0, irq}, 32'd1);
    rd(2'd1, 3'b000, "R7 mask read back");
    rd(2'd0, 3'b000, "R3 both bits pending");
    // R7 upper mask bits do not gate
    wrm(2'd1, 32'h0000_0007);
    idle(3'b111);
    check(irq === 1'b0, "R7 upper mask bits ignored for gating", {31'd0, irq}, 32'd0);
    rd(2'd0, 3'b000, "R2 all three set");
    // R4 request in read cycle kept
    wrm(2'd1, 32'hFFFF_FFF8);
    idle(3'b001);
    rd(2'd0, 3'b100, "R4 read before coincident request");
    check(irq === 1'b1, "R4 coincident misc raises irq", {31'd0, irq}, 32'd1);
    rd(2'd0, 3'b000, "R4 coincident misc kept");
    // R5 held request
    idle(3'b001);
    rd(2'd0, 3'b001, "R5 held receive first read");
    rd(2'd0, 3'b001, "R5 held receive second read");
    rd(2'd0, 3'b000, "R5 held receive third read");
    rd(2'd0, 3'b000, "R5 cleared after drop");
    // R8 write to summary ignored
    idle(3'b010);
    wrm(2'd0, 32'h0000_0000);
    wrm(2'd0, 32'h0000_0007);
    rd(2'd0, 3'b000, "R8 summary write ignored");
    // R9 zero summary with open mask
    wrm(2'd1, 32'h0000_0000);
    idle(3'b000);
    check(irq === 1'b0, "R9 zero summary all-zero mask", {31'd0, irq}, 32'd0);
    rd(2'd2, 3'b000, "R3 unused address reads zero");
    idle(3'b000);
    idle(3'b000);
    check(expq.size() == 0, "R3 all reads answered", expq.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule